// File: doc/BRIEF.md
# Multi-Edge PWM Output Stage with Shadow Compare Sequencing

This block produces two PWM outputs from a private up-down time base. The counter climbs from 0 to `PRD` and falls back to 0, so one period lasts `2*(PRD+1)` clocks. With the default `PRD` of 1999 that is 4000 clocks, which is 50 kHz at a 200 MHz clock. The counter is folded into a period position that runs from 0 to `2*PRD+1`. Eight compare values each mark one output edge at a chosen position. This lets one period hold several pulses, so the output can run at a multiple of the base frequency. Eight evenly spaced edges on A give 200 kHz at 50% duty. Four edges on each output give 100 kHz, and the two outputs can be made complementary.

The compare values live in an active set that the edge logic reads. Software can write an active value directly, and the write takes effect on the next clock. It can also stage values in three shadow sets. A small sequencer copies shadow sets into the active set, and only at the last clock of a period, so new values always start at position 0.

The sequencer has five states. `ST_DIRECT` makes no transfers. `ST_ONCE` copies set 3 at every boundary. `ST_SET3`, `ST_SET2` and `ST_SET1` form a repeating cycle, and each set is held for its repeat count plus one periods. The transitions, all taken at a boundary, are:
- enter-multi: from `ST_DIRECT` or `ST_ONCE` to `ST_SET3`, loading set 3.
- advance: from `ST_SET3` to `ST_SET2`, loading set 2, and from `ST_SET2` to `ST_SET1`, loading set 1.
- wrap: from `ST_SET1` to `ST_SET3`, loading set 3 and raising `seq_irq`.
- leave-multi: to `ST_ONCE`, loading set 3, or to `ST_DIRECT`.
- stay-once: from `ST_ONCE` to `ST_ONCE`, loading set 3.

Top module: `mep_stage`

## Requirements
- R1: After reset the period position is 0 in the first clock and advances by one each clock, wrapping from `2*PRD+1` to 0. An edge whose compare value equals the position in a clock changes the output in the next clock.
- R2: When `alloc_split` is 0, all eight compare values drive `pwm_a` and `pwm_b` stays low.
- R3: When `alloc_split` is 1, compare values 1 to 4 (`wr_idx` 0 to 3) drive `pwm_a` and values 5 to 8 (`wr_idx` 4 to 7) drive `pwm_b`.
- R4: Edges with odd numbers (1, 3, 5, 7) set their output and edges with even numbers clear it. If several edges match in the same clock, the highest-numbered one wins. At position 0 the output is low unless an edge matches there.
- R5: A write with `wr_set` = 0 changes active value `wr_idx` for the next clock. A write with `wr_set` = 1, 2 or 3 changes only shadow set 1, 2 or 3.
- R6: `load_mode` 2'b00 and 2'b11 select direct operation. In direct operation the active values change only through active writes.
- R7: `load_mode` 2'b01 selects multi-set loading. At the first boundary set 3 is loaded. Set 3 is then held for `rpt_set3`+1 periods, set 2 for `rpt_set2`+1 and set 1 for `rpt_set1`+1, and the cycle repeats from set 3.
- R8: `seq_irq` is high for exactly one clock, the first clock of the period in which set 3 is reloaded after set 1. It never rises in any other mode.
- R9: `load_mode` 2'b10 copies shadow set 3 into the active set at every boundary.
- R10: Mode changes and shadow transfers take effect only at the last clock of a period. A transfer overrides an active write in the same clock.
- R11: Reset clears all compare values, drives both outputs and `seq_irq` low, and selects `ST_DIRECT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_split | input | 1 | 0: all edges on A; 1: edges 1-4 on A, 5-8 on B |
| load_mode | input | 2 | 00/11 direct, 01 multi-set, 10 set-3 reload |
| wr_en | input | 1 | Compare write strobe |
| wr_set | input | 2 | 0 active set, 1..3 shadow set |
| wr_idx | input | 3 | Compare value index, 0 = edge 1 |
| wr_data | input | POS_W | Compare position |
| rpt_set1 | input | RPT_W | Extra periods for set 1 |
| rpt_set2 | input | RPT_W | Extra periods for set 2 |
| rpt_set3 | input | RPT_W | Extra periods for set 3 |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| seq_irq | output | 1 | Multi-set cycle complete pulse |

## Verification
The assertions assume that the period spans at least two clocks. They also assume that the active set changes only through an active write or a boundary transfer, with no other path into it. Compare values beyond the last position never match, so the stimulus keeps written values inside the period. It also keeps the repeat counts small, so that many complete multi-set cycles fit in the run. The random phase changes modes, allocation and repeat counts at arbitrary clocks. This exercises mid-period mode changes and writes that collide with transfers.

// File: rtl/mep_pkg.sv
package mep_pkg;
    localparam int NUM_EDGES = 8;
    localparam int NUM_SETS  = 3;

    typedef enum logic [1:0] {
        MODE_DIRECT     = 2'b00,
        MODE_MULTI      = 2'b01,
        MODE_ONCE       = 2'b10,
        MODE_DIRECT_ALT = 2'b11
    } load_mode_e;

    typedef enum logic [2:0] {
        ST_DIRECT,
        ST_ONCE,
        ST_SET3,
        ST_SET2,
        ST_SET1
    } seq_state_e;
endpackage

// File: rtl/mep_timebase.sv
module mep_timebase #(
    parameter int PRD   = 1999,
    parameter int POS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos,
    output logic             prd_end
);
    localparam logic [POS_W-1:0] TOP  = POS_W'(PRD);
    localparam logic [POS_W-1:0] LAST = POS_W'(2 * PRD + 1);

    logic [POS_W-1:0] cnt;
    logic             up;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (up) begin
            if (cnt == TOP) up <= 1'b0;
            else            cnt <= cnt + 1'b1;
        end else begin
            if (cnt == '0)  up <= 1'b1;
            else            cnt <= cnt - 1'b1;
        end
    end

    assign pos     = up ? cnt : (LAST - cnt);
    assign prd_end = !up && (cnt == '0);
endmodule

// File: rtl/mep_seq_ctrl.sv
module mep_seq_ctrl
    import mep_pkg::*;
#(
    parameter int RPT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prd_end,
    input  logic [1:0]       mode,
    input  logic [RPT_W-1:0] rpt1,
    input  logic [RPT_W-1:0] rpt2,
    input  logic [RPT_W-1:0] rpt3,
    output logic             xfer_en,
    output logic [1:0]       xfer_sel,
    output logic             irq,
    output seq_state_e       state
);
    seq_state_e       nxt;
    logic [RPT_W-1:0] rep, rep_nxt, cur_rpt;
    logic             irq_nxt, want_multi, want_once;

    assign want_multi = (mode == MODE_MULTI);
    assign want_once  = (mode == MODE_ONCE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DIRECT;
            rep   <= '0;
            irq   <= 1'b0;
        end else begin
            state <= nxt;
            rep   <= rep_nxt;
            irq   <= irq_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_SET2: cur_rpt = rpt2;
            ST_SET1: cur_rpt = rpt1;
            default: cur_rpt = rpt3;
        endcase
    end

    always_comb begin
        nxt      = state;
        rep_nxt  = rep;
        xfer_en  = 1'b0;
        xfer_sel = 2'd2;
        irq_nxt  = 1'b0;
        if (prd_end) begin
            unique case (state)
                ST_DIRECT, ST_ONCE: begin
                    rep_nxt = '0;
                    if (want_multi) begin
                        nxt     = ST_SET3;
                        xfer_en = 1'b1;
                    end else if (want_once) begin
                        nxt     = ST_ONCE;
                        xfer_en = 1'b1;
                    end else begin
                        nxt = ST_DIRECT;
                    end
                end
                ST_SET3, ST_SET2, ST_SET1: begin
                    if (!want_multi) begin
                        rep_nxt = '0;
                        xfer_en = want_once;
                        nxt     = want_once ? ST_ONCE : ST_DIRECT;
                    end else if (rep >= cur_rpt) begin
                        rep_nxt = '0;
                        xfer_en = 1'b1;
                        unique case (state)
                            ST_SET3: begin nxt = ST_SET2; xfer_sel = 2'd1; end
                            ST_SET2: begin nxt = ST_SET1; xfer_sel = 2'd0; end
                            default: begin nxt = ST_SET3; xfer_sel = 2'd2; irq_nxt = 1'b1; end
                        endcase
                    end else begin
                        rep_nxt = rep + 1'b1;
                    end
                end
                default: nxt = ST_DIRECT;
            endcase
        end
    end
endmodule

// File: rtl/mep_cmp_bank.sv
module mep_cmp_bank
    import mep_pkg::*;
#(
    parameter int NE    = NUM_EDGES,
    parameter int POS_W = 12,
    localparam int IDX_W = $clog2(NE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_set,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [POS_W-1:0]    wr_data,
    input  logic                xfer_en,
    input  logic [1:0]          xfer_sel,
    output logic [NE*POS_W-1:0] act_flat
);
    logic [POS_W-1:0] act [NE];
    logic [POS_W-1:0] shd [NUM_SETS][NE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) begin
                act[i] <= '0;
                for (int s = 0; s < NUM_SETS; s++) shd[s][i] <= '0;
            end
        end else begin
            if (xfer_en) begin
                for (int i = 0; i < NE; i++) act[i] <= shd[xfer_sel][i];
            end else if (wr_en && wr_set == 2'd0) begin
                act[wr_idx] <= wr_data;
            end
            if (wr_en && wr_set != 2'd0) shd[wr_set - 2'd1][wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < NE; g++) begin : g_flat
        assign act_flat[g*POS_W +: POS_W] = act[g];
    end
endmodule

// File: rtl/mep_edge_out.sv
module mep_edge_out #(
    parameter int NE    = 8,
    parameter int POS_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                split,
    input  logic [POS_W-1:0]    pos,
    input  logic [NE*POS_W-1:0] act_flat,
    output logic                pwm_a,
    output logic                pwm_b
);
    localparam int HALF = NE / 2;

    logic [NE-1:0] hit;
    logic          na, nb;

    for (genvar g = 0; g < NE; g++) begin : g_hit
        assign hit[g] = (act_flat[g*POS_W +: POS_W] == pos);
    end

    always_comb begin
        na = (pos == '0) ? 1'b0 : pwm_a;
        nb = (pos == '0) ? 1'b0 : pwm_b;
        for (int i = 0; i < NE; i++) begin
            if (hit[i] && (!split || i < HALF)) na = ((i % 2) == 0);
            if (hit[i] && split && i >= HALF)   nb = ((i % 2) == 0);
        end
        if (!split) nb = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_a <= 1'b0;
            pwm_b <= 1'b0;
        end else begin
            pwm_a <= na;
            pwm_b <= nb;
        end
    end
endmodule

// File: rtl/mep_stage.sv
module mep_stage
    import mep_pkg::*;
#(
    parameter int PRD   = 1999,
    parameter int RPT_W = 4,
    localparam int POS_W = $clog2(2 * (PRD + 1)),
    localparam int IDX_W = $clog2(NUM_EDGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_split,
    input  logic [1:0]       load_mode,
    input  logic             wr_en,
    input  logic [1:0]       wr_set,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [POS_W-1:0] wr_data,
    input  logic [RPT_W-1:0] rpt_set1,
    input  logic [RPT_W-1:0] rpt_set2,
    input  logic [RPT_W-1:0] rpt_set3,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             seq_irq
);
    logic [POS_W-1:0]           pos;
    logic                       prd_end, xfer_en;
    logic [1:0]                 xfer_sel;
    logic [NUM_EDGES*POS_W-1:0] act_flat;
    seq_state_e                 state;

    mep_timebase #(.PRD(PRD), .POS_W(POS_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .pos(pos), .prd_end(prd_end)
    );

    mep_seq_ctrl #(.RPT_W(RPT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .prd_end(prd_end), .mode(load_mode),
        .rpt1(rpt_set1), .rpt2(rpt_set2), .rpt3(rpt_set3),
        .xfer_en(xfer_en), .xfer_sel(xfer_sel), .irq(seq_irq), .state(state)
    );

    mep_cmp_bank #(.NE(NUM_EDGES), .POS_W(POS_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set),
        .wr_idx(wr_idx), .wr_data(wr_data), .xfer_en(xfer_en),
        .xfer_sel(xfer_sel), .act_flat(act_flat)
    );

    mep_edge_out #(.NE(NUM_EDGES), .POS_W(POS_W)) u_out (
        .clk(clk), .rst_n(rst_n), .split(alloc_split), .pos(pos),
        .act_flat(act_flat), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );
endmodule

// File: rtl/mep_stage_chk.sv
module mep_stage_chk
    import mep_pkg::*;
#(
    parameter int POS_W = 12,
    parameter int NE    = 8,
    parameter int LAST  = 3999
) (
    input logic                clk,
    input logic                rst_n,
    input logic                alloc_split,
    input logic [1:0]          mode,
    input logic                wr_en,
    input logic [1:0]          wr_set,
    input logic [POS_W-1:0]    pos,
    input logic                prd_end,
    input logic [NE*POS_W-1:0] act_flat,
    input logic                pwm_b,
    input logic                seq_irq,
    input seq_state_e          state
);
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_W'(LAST)); // R1
    AST_B_LOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!alloc_split) |-> !pwm_b); // R2
    AST_DIRECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIRECT && $past(state == ST_DIRECT) && !$past(wr_en && wr_set == 2'd0))
        |-> $stable(act_flat)); // R6
    AST_XFER_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_flat) && !$past(wr_en && wr_set == 2'd0)) |-> $past(prd_end)); // R10
    AST_STATE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(prd_end) |-> $stable(state)); // R10
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_irq |=> !seq_irq); // R8
    AST_IRQ_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        seq_irq |-> (pos == '0 && $past(mode) == MODE_MULTI)); // R8
    AST_IRQ_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_irq |-> state == ST_SET3); // R7
endmodule

bind mep_stage mep_stage_chk #(.POS_W(POS_W), .NE(NUM_EDGES), .LAST(2 * PRD + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_split(alloc_split), .mode(load_mode),
    .wr_en(wr_en), .wr_set(wr_set), .pos(pos), .prd_end(prd_end),
    .act_flat(act_flat), .pwm_b(pwm_b), .seq_irq(seq_irq), .state(state)
);

// File: tb/mep_stage_bench.sv
`timescale 1ns/1ps
module mep_stage_bench;
    localparam int PRD   = 19;
    localparam int RPT_W = 4;
    localparam int LAST  = 2 * PRD + 1;
    localparam int POS_W = $clog2(2 * (PRD + 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_split = 1'b0;
    logic [1:0] load_mode = 2'b00;
    logic wr_en = 1'b0;
    logic [1:0] wr_set = 2'd0;
    logic [2:0] wr_idx = 3'd0;
    logic [POS_W-1:0] wr_data = '0;
    logic [RPT_W-1:0] rpt_set1 = '0, rpt_set2 = '0, rpt_set3 = '0;
    logic pwm_a, pwm_b, seq_irq;

    always #5 clk = ~clk;

    mep_stage #(.PRD(PRD), .RPT_W(RPT_W)) u_mep_stage (
        .clk(clk), .rst_n(rst_n), .alloc_split(alloc_split), .load_mode(load_mode),
        .wr_en(wr_en), .wr_set(wr_set), .wr_idx(wr_idx), .wr_data(wr_data),
        .rpt_set1(rpt_set1), .rpt_set2(rpt_set2), .rpt_set3(rpt_set3),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .seq_irq(seq_irq)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R11";
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural reference model
    int m_pos, m_st, m_rep;
    int m_act [8];
    int m_sh [3][8];
    bit m_a, m_b, m_irq;

    function automatic int rpt_of(int st);
        if (st == 2) return int'(rpt_set3);
        if (st == 3) return int'(rpt_set2);
        return int'(rpt_set1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_st = 0; m_rep = 0;
            m_a = 0; m_b = 0; m_irq = 0;
            for (int i = 0; i < 8; i++) begin
                m_act[i] = 0;
                for (int s = 0; s < 3; s++) m_sh[s][i] = 0;
            end
        end else begin
            bit na, nb, nirq;
            int xf;
            na = (m_pos == 0) ? 1'b0 : m_a;
            nb = (m_pos == 0) ? 1'b0 : m_b;
            for (int i = 0; i < 8; i++) begin
                if (m_act[i] == m_pos) begin
                    if (!alloc_split || i < 4) na = (i % 2 == 0);
                    else nb = (i % 2 == 0);
                end
            end
            if (!alloc_split) nb = 1'b0;
            nirq = 0;
            xf = -1;
            if (m_pos == LAST) begin
                if (m_st <= 1) begin
                    m_rep = 0;
                    if (load_mode == 2'b01) begin m_st = 2; xf = 2; end
                    else if (load_mode == 2'b10) begin m_st = 1; xf = 2; end
                    else m_st = 0;
                end else if (load_mode != 2'b01) begin
                    m_rep = 0;
                    if (load_mode == 2'b10) begin m_st = 1; xf = 2; end
                    else m_st = 0;
                end else if (m_rep >= rpt_of(m_st)) begin
                    m_rep = 0;
                    if (m_st == 2) begin m_st = 3; xf = 1; end
                    else if (m_st == 3) begin m_st = 4; xf = 0; end
                    else begin m_st = 2; xf = 2; nirq = 1; end
                end else begin
                    m_rep++;
                end
            end
            if (xf >= 0) begin
                for (int i = 0; i < 8; i++) m_act[i] = m_sh[xf][i];
            end else if (wr_en && wr_set == 2'd0) begin
                m_act[wr_idx] = int'(wr_data);
            end
            if (wr_en && wr_set != 2'd0) m_sh[wr_set - 1][wr_idx] = int'(wr_data);
            m_a = na; m_b = nb; m_irq = nirq;
            m_pos = (m_pos == LAST) ? 0 : m_pos + 1;
        end
    end

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            chk(tag, "pwm_a", pwm_a, m_a);
            chk(tag, "pwm_b", pwm_b, m_b);
            chk(tag, "seq_irq", seq_irq, m_irq);
        end
    end

    task automatic wr(int set, int idx, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_set = 2'(set); wr_idx = 3'(idx); wr_data = POS_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic align(int p);
        do @(negedge clk); while (m_pos != p);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int t0, t1, cnt;
        bit prev;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11", "pwm_a in reset", pwm_a, 0);
        chk("R11", "pwm_b in reset", pwm_b, 0);
        chk("R11", "seq_irq in reset", seq_irq, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        for (int k = 0; k < 2 * (LAST + 1); k++) begin
            @(negedge clk);
            chk("R11", "pwm_a after reset", pwm_a, 0);
        end

        // R2 R4 R5 R1: eight evenly spaced edges on A
        tag = "R2 R4 R5 R1";
        for (int i = 0; i < 8; i++) wr(0, i, i * 5);
        align(1);
        cnt = 0; prev = pwm_a;
        for (int k = 0; k < LAST + 1; k++) begin
            @(negedge clk);
            if (pwm_a && !prev) cnt++;
            prev = pwm_a;
        end
        chk("R2", "rising edges per period", cnt, 4);

        // R3: split allocation, complementary pair
        tag = "R3 R5";
        alloc_split = 1'b1;
        wr(0, 0, 0); wr(0, 1, 10); wr(0, 2, 20); wr(0, 3, 30);
        wr(0, 4, 10); wr(0, 5, 20); wr(0, 6, 30); wr(0, 7, 0);
        align(2);
        for (int k = 0; k < LAST + 1; k++) begin
            @(negedge clk);
            chk("R3", "pwm_a vs ~pwm_b", pwm_a, !pwm_b);
        end

        // R4: coincident edges, higher number wins
        tag = "R4";
        wr(0, 0, 15); wr(0, 1, 15);
        repeat (2 * (LAST + 1)) @(negedge clk);

        // R7 R8: multi-set sequence 5/3/1 periods
        tag = "R7 R8";
        alloc_split = 1'b0;
        for (int s = 1; s <= 3; s++)
            for (int i = 0; i < 8; i++) wr(s, i, i * 5 + (3 - s));
        rpt_set3 = 4'd4; rpt_set2 = 4'd2; rpt_set1 = 4'd0;
        load_mode = 2'b01;
        t0 = 0; t1 = 0; cnt = 0;
        for (int k = 0; k < 30 * (LAST + 1) && cnt < 2; k++) begin
            @(negedge clk);
            if (seq_irq) begin
                if (cnt == 0) t0 = k; else t1 = k;
                cnt++;
            end
        end
        chk("R8", "irq pulses seen", cnt, 2);
        chk("R7", "clocks between irq", t1 - t0, 9 * (LAST + 1));

        // R10: active writes while sequencing
        tag = "R10 R5";
        for (int k = 0; k < 60; k++) begin
            wr(0, $urandom_range(0, 7), $urandom_range(0, LAST));
            repeat ($urandom_range(0, 9)) @(negedge clk);
        end

        // R9: set 3 reload every period
        tag = "R9 R10";
        load_mode = 2'b10;
        cnt = 0;
        for (int p = 0; p < 4; p++) begin
            align(LAST / 2);
            wr(3, p, (p * 7 + 3) % (LAST + 1));
            for (int k = 0; k < LAST; k++) begin
                @(negedge clk);
                if (seq_irq) cnt++;
            end
        end
        chk("R8", "irq pulses in reload mode", cnt, 0);

        // R6: alternate direct code ignores shadows
        tag = "R6";
        load_mode = 2'b11;
        for (int i = 0; i < 8; i++) wr(3, i, (i * 11) % (LAST + 1));
        repeat (3 * (LAST + 1)) @(negedge clk);

        // random mixture
        tag = "R1 R3 R5 R6 R7 R9 R10";
        for (int k = 0; k < 2500; k++) begin
            if ($urandom_range(0, 3) == 0) wr($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, LAST));
            if ($urandom_range(0, 40) == 0) load_mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 60) == 0) alloc_split = ~alloc_split;
            if ($urandom_range(0, 50) == 0) begin
                rpt_set1 = 4'($urandom_range(0, 3));
                rpt_set2 = 4'($urandom_range(0, 3));
                rpt_set3 = 4'($urandom_range(0, 3));
            end
            repeat ($urandom_range(0, 20)) @(negedge clk);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule